// File: doc/BRIEF.md
# Clock-Gated Time Slot Map Registers

This block is a bank of four small maps that a serial port uses to assign each time slot to a channel. There is a time-slot map and a subchannel map for each direction, receive and transmit. Each map holds one entry per time slot. A host writes and reads the maps over a simple register bus. The serial-side logic reads all four entries for one slot at a time through a separate slot-select port.

The maps can only be reached while the serial line clock is running. A two-flop synchroniser brings the line clock into the host domain, and an edge detector watches it. A two-state machine, with states `ST_ABSENT` and `ST_PRESENT`, decides whether the clock is present:

- `ST_ABSENT` moves to `ST_PRESENT` on any synchronised rising edge (transition *edge_found*).
- `ST_PRESENT` returns to `ST_ABSENT` after `GAP_LIMIT` host clocks in a row with no edge (transition *gap_expired*).

While the clock is absent, host writes are dropped and host reads return all ones. The transmit maps are write-only: a host read of a transmit map always returns all ones.

Top module: `tsmap_regs`

## Requirements
- R1: After reset, every entry of all four maps is zero, `line_live` is 0, and `host_rdata` is 0.
- R2: `line_live` rises one host clock after a synchronised rising edge of `ser_clk` is detected. It falls after 16 consecutive host clocks in which no such edge is seen.
- R3: Address decode: bits 4:0 give the slot. Bit 6 selects the direction (0 receive, 1 transmit). Bit 5 selects the map kind (0 time-slot map, 1 subchannel map). While `line_live` is 1, a write with `host_we` stores `host_wdata` in the addressed entry.
- R4: While `line_live` is 1, a read with `host_re` of a receive map (bit 6 = 0) returns the stored entry on `host_rdata` one host clock later. `host_rdata` holds its value when `host_re` is 0.
- R5: A read of a transmit map (bit 6 = 1) always returns 8'hFF. Writes to the transmit maps still take effect and are visible on the serial-side outputs.
- R6: A write made while `line_live` is 0 is discarded: no map entry changes.
- R7: A read made while `line_live` is 0 returns 8'hFF, whatever the address.
- R8: `rx_slot_entry`, `rx_sub_entry`, `tx_slot_entry` and `tx_sub_entry` show, combinationally, the entry of each map at slot `slot_sel`.
- R9: When a read and a write hit the same entry in the same cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial line clock (asynchronous to `clk`) |
| host_addr | input | 7 | Host address: direction, map kind, slot |
| host_we | input | 1 | Host write enable |
| host_wdata | input | 8 | Host write data |
| host_re | input | 1 | Host read enable |
| host_rdata | output | 8 | Registered host read data |
| line_live | output | 1 | Serial clock present flag |
| slot_sel | input | 5 | Slot index used by the serial side |
| rx_slot_entry | output | 8 | Receive time-slot map entry at `slot_sel` |
| rx_sub_entry | output | 8 | Receive subchannel map entry at `slot_sel` |
| tx_slot_entry | output | 8 | Transmit time-slot map entry at `slot_sel` |
| tx_sub_entry | output | 8 | Transmit subchannel map entry at `slot_sel` |

## Verification
The main function is exercised with four kinds of pattern:

- **Random reads and writes over the whole address space, line clock running.** Every read is compared against a shadow model. This separates correct direction and kind decoding from cross-map aliasing, and it shows the transmit maps returning all ones while keeping the data that was written.
- **The same random traffic after the line clock has stopped.** The slot port then exposes every entry, which shows that blocked writes changed nothing and that blocked reads return all ones.
- **Stopping and restarting the line clock.** This exercises both transitions of the presence state machine.
- **A directed read and write to the same entry in one cycle.** This shows whether the read sees the old contents or the new.

// File: rtl/tsmap_pkg.sv
`timescale 1ns/1ps
package tsmap_pkg;
    localparam int N_MAPS = 4;
    localparam int MAP_W  = 2;

    typedef enum logic {
        ST_ABSENT  = 1'b0,
        ST_PRESENT = 1'b1
    } line_state_e;

    // map index = {direction, kind}: 0 rx slot, 1 rx sub, 2 tx slot, 3 tx sub
    function automatic logic is_tx(input logic [MAP_W-1:0] idx);
        return idx[1];
    endfunction
endpackage

// File: rtl/line_sense.sv
`timescale 1ns/1ps
module line_sense #(
    parameter int GAP_LIMIT = 16,
    localparam int GAP_W = $clog2(GAP_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    output logic edge_seen,
    output logic line_live
);
    import tsmap_pkg::*;

    logic s_meta, s_sync, s_prev;
    logic [GAP_W-1:0] gap;
    line_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_meta <= 1'b0;
            s_sync <= 1'b0;
            s_prev <= 1'b0;
        end else begin
            s_meta <= ser_clk;
            s_sync <= s_meta;
            s_prev <= s_sync;
        end
    end

    assign edge_seen = s_sync & ~s_prev;

    always_ff @(posedge clk) begin
        if (!rst_n)
            gap <= '0;
        else if (edge_seen)
            gap <= '0;
        else if (gap < GAP_W'(GAP_LIMIT - 1))
            gap <= gap + 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ABSENT:  if (edge_seen) state_nx = ST_PRESENT;
            ST_PRESENT: if (!edge_seen && gap == GAP_W'(GAP_LIMIT - 1))
                            state_nx = ST_ABSENT;
            default:    state_nx = ST_ABSENT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ABSENT;
        else        state <= state_nx;
    end

    always_comb begin
        line_live = (state == ST_PRESENT);
    end
endmodule

// File: rtl/map_store.sv
`timescale 1ns/1ps
module map_store #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] raddr_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [IDX_W-1:0] raddr_b,
    output logic [WIDTH-1:0] rdata_b
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/host_rd.sv
`timescale 1ns/1ps
module host_rd #(
    parameter int WIDTH = 8,
    parameter int N_MAPS = 4,
    localparam int SEL_W = $clog2(N_MAPS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        re,
    input  logic                        live,
    input  logic [SEL_W-1:0]            map_idx,
    input  logic [N_MAPS-1:0][WIDTH-1:0] cand,
    output logic [WIDTH-1:0]            rdata
);
    import tsmap_pkg::*;

    logic [WIDTH-1:0] pick;

    always_comb begin
        if (!live || is_tx(map_idx))
            pick = '1;
        else
            pick = cand[map_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= pick;
    end
endmodule

// File: rtl/tsmap_regs.sv
`timescale 1ns/1ps
module tsmap_regs #(
    parameter int SLOTS     = 32,
    parameter int ENTRY_W   = 8,
    parameter int GAP_LIMIT = 16,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ADDR_W = SLOT_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_we,
    input  logic [ENTRY_W-1:0] host_wdata,
    input  logic               host_re,
    output logic [ENTRY_W-1:0] host_rdata,
    output logic               line_live,
    input  logic [SLOT_W-1:0]  slot_sel,
    output logic [ENTRY_W-1:0] rx_slot_entry,
    output logic [ENTRY_W-1:0] rx_sub_entry,
    output logic [ENTRY_W-1:0] tx_slot_entry,
    output logic [ENTRY_W-1:0] tx_sub_entry
);
    import tsmap_pkg::*;

    logic                          edge_seen;
    logic [MAP_W-1:0]              map_idx;
    logic [SLOT_W-1:0]             slot_idx;
    logic [N_MAPS-1:0][ENTRY_W-1:0] host_view;
    logic [N_MAPS-1:0][ENTRY_W-1:0] slot_view;

    assign map_idx  = host_addr[ADDR_W-1:SLOT_W];
    assign slot_idx = host_addr[SLOT_W-1:0];

    line_sense #(.GAP_LIMIT(GAP_LIMIT)) u_sense (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk),
        .edge_seen(edge_seen), .line_live(line_live)
    );

    for (genvar m = 0; m < N_MAPS; m++) begin : g_map
        logic wr_hit;
        assign wr_hit = host_we && line_live && (map_idx == MAP_W'(m));
        map_store #(.DEPTH(SLOTS), .WIDTH(ENTRY_W)) u_store (
            .clk(clk), .rst_n(rst_n),
            .we(wr_hit), .waddr(slot_idx), .wdata(host_wdata),
            .raddr_a(slot_idx), .rdata_a(host_view[m]),
            .raddr_b(slot_sel), .rdata_b(slot_view[m])
        );
    end

    host_rd #(.WIDTH(ENTRY_W), .N_MAPS(N_MAPS)) u_rd (
        .clk(clk), .rst_n(rst_n), .re(host_re), .live(line_live),
        .map_idx(map_idx), .cand(host_view), .rdata(host_rdata)
    );

    assign rx_slot_entry = slot_view[0];
    assign rx_sub_entry  = slot_view[1];
    assign tx_slot_entry = slot_view[2];
    assign tx_sub_entry  = slot_view[3];
endmodule

// File: rtl/tsmap_regs_chk.sv
`timescale 1ns/1ps
module tsmap_regs_chk #(
    parameter int SLOTS     = 32,
    parameter int ENTRY_W   = 8,
    parameter int GAP_LIMIT = 16,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ADDR_W = SLOT_W + 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               edge_seen,
    input logic               line_live,
    input logic [ADDR_W-1:0]  host_addr,
    input logic               host_re,
    input logic [ENTRY_W-1:0] host_rdata,
    input logic [SLOT_W-1:0]  slot_sel,
    input logic [ENTRY_W-1:0] rx_slot_entry,
    input logic [ENTRY_W-1:0] rx_sub_entry,
    input logic [ENTRY_W-1:0] tx_slot_entry,
    input logic [ENTRY_W-1:0] tx_sub_entry
);
    localparam int Q_W = $clog2(GAP_LIMIT + 1) + 1;
    logic [Q_W-1:0] quiet;

    always_ff @(posedge clk) begin
        if (!rst_n)          quiet <= '0;
        else if (edge_seen)  quiet <= '0;
        else if (quiet != '1) quiet <= quiet + 1'b1;
    end

    // R2
    p_edge_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> line_live);
    // R2
    p_gap_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet >= Q_W'(GAP_LIMIT)) |-> !line_live);
    // R5
    p_tx_read_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && host_addr[ADDR_W-1]) |=> host_rdata == '1);
    // R7
    p_absent_read_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && !line_live) |=> host_rdata == '1);
    // R6
    p_blocked_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !line_live |=> (slot_sel != $past(slot_sel)) ||
            $stable({rx_slot_entry, rx_sub_entry, tx_slot_entry, tx_sub_entry}));
    // R4, R9
    p_rx_read_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && line_live && host_addr[ADDR_W-1:SLOT_W] == 2'b00 &&
         host_addr[SLOT_W-1:0] == slot_sel) |=> host_rdata == $past(rx_slot_entry));
endmodule

bind tsmap_regs tsmap_regs_chk #(
    .SLOTS(SLOTS), .ENTRY_W(ENTRY_W), .GAP_LIMIT(GAP_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .edge_seen(edge_seen), .line_live(line_live),
    .host_addr(host_addr), .host_re(host_re), .host_rdata(host_rdata),
    .slot_sel(slot_sel), .rx_slot_entry(rx_slot_entry), .rx_sub_entry(rx_sub_entry),
    .tx_slot_entry(tx_slot_entry), .tx_sub_entry(tx_sub_entry)
);

// File: tb/tsmap_regs_test.sv
`timescale 1ns/1ps
module tsmap_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_en = 1'b0;
    logic [6:0] host_addr = '0;
    logic       host_we = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       host_re = 1'b0;
    logic [7:0] host_rdata;
    logic       line_live;
    logic [4:0] slot_sel = '0;
    logic [7:0] rx_slot_entry, rx_sub_entry, tx_slot_entry, tx_sub_entry;

    int total = 0;
    int bad = 0;
    logic [7:0] model [4][32];

    always #4 clk = ~clk;
    always begin
        #24;
        if (ser_en) ser_clk = ~ser_clk;
        else        ser_clk = 1'b0;
    end

    tsmap_regs uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk),
        .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
        .host_re(host_re), .host_rdata(host_rdata), .line_live(line_live),
        .slot_sel(slot_sel), .rx_slot_entry(rx_slot_entry), .rx_sub_entry(rx_sub_entry),
        .tx_slot_entry(tx_slot_entry), .tx_sub_entry(tx_sub_entry)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic live, input logic [6:0] a);
        if (!live || a[6]) return 8'hFF;
        return model[a[6:5]][a[4:0]];
    endfunction

    task automatic do_write(input logic [6:0] a, input logic [7:0] d, input logic live);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        if (live) model[a[6:5]][a[4:0]] = d;
    endtask

    task automatic do_read(input logic [6:0] a, input logic live, input string req);
        @(negedge clk);
        host_addr = a; host_re = 1'b1;
        @(negedge clk);
        host_re = 1'b0;
        chk(req, host_rdata, exp_read(live, a));
    endtask

    task automatic check_slot(input logic [4:0] s, input string req);
        @(negedge clk);
        slot_sel = s;
        #1;
        chk(req, {rx_slot_entry, rx_sub_entry, tx_slot_entry, tx_sub_entry},
            {model[0][s], model[1][s], model[2][s], model[3][s]});
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 32; s++) model[m][s] = 8'h00;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 live", line_live, 0);
        chk("R1 rdata", host_rdata, 0);
        check_slot(5'd0, "R1 slot0");
        check_slot(5'd31, "R1 slot31");

        // R7 read with no line clock
        do_read(7'h05, 1'b0, "R7 absent read");

        // R2 clock appears
        ser_en = 1'b1;
        repeat (30) @(negedge clk);
        chk("R2 live rise", line_live, 1);

        // R3 R4 R5 directed decode
        do_write(7'h03, 8'hA1, 1'b1);
        do_write(7'h23, 8'hB2, 1'b1);
        do_write(7'h43, 8'hC3, 1'b1);
        do_write(7'h63, 8'hD4, 1'b1);
        check_slot(5'd3, "R3 R8 decode");
        do_read(7'h03, 1'b1, "R4 rx slot read");
        do_read(7'h23, 1'b1, "R4 rx sub read");
        do_read(7'h43, 1'b1, "R5 tx slot read ones");
        do_read(7'h63, 1'b1, "R5 tx sub read ones");

        // R9 same-cycle read and write
        @(negedge clk);
        host_addr = 7'h03; host_wdata = 8'h5E; host_we = 1'b1; host_re = 1'b1;
        @(negedge clk);
        host_we = 1'b0; host_re = 1'b0;
        chk("R9 old value", host_rdata, 8'hA1);
        model[0][3] = 8'h5E;
        do_read(7'h03, 1'b1, "R9 new value");

        // R4 hold when not reading
        repeat (3) @(negedge clk);
        chk("R4 hold", host_rdata, 8'h5E);

        // random traffic with clock present
        for (int i = 0; i < 400; i++) begin
            logic [6:0] a;
            a = 7'($urandom % 128);
            if ($urandom % 2) do_write(a, 8'($urandom), 1'b1);
            else              do_read(a, 1'b1, "R4 R5 random read");
            if (i % 25 == 0) check_slot(5'($urandom % 32), "R8 random slot");
        end
        chk("R2 live held", line_live, 1);

        // R2 clock stops
        ser_en = 1'b0;
        repeat (40) @(negedge clk);
        chk("R2 live fall", line_live, 0);

        // R6 R7 blocked access
        for (int i = 0; i < 100; i++) begin
            logic [6:0] a;
            a = 7'($urandom % 128);
            if ($urandom % 2) do_write(a, 8'($urandom), 1'b0);
            else              do_read(a, 1'b0, "R7 random absent read");
        end
        for (int s = 0; s < 32; s++) check_slot(5'(s), "R6 blocked write");

        // R2 clock returns, maps intact
        ser_en = 1'b1;
        repeat (30) @(negedge clk);
        chk("R2 live again", line_live, 1);
        for (int s = 0; s < 32; s += 7) do_read({2'b00, 5'(s)}, 1'b1, "R4 after restart");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule